// File: doc/BRIEF.md
# Stereo Digital Volume with Staged and Zero-Cross Gain Update

This block scales a stereo stream of signed samples by a per-channel digital gain. Each channel has an 8-bit gain code. A code maps to a gain in half-decibel steps around a unity point. A lookup table built at elaboration turns the code into a fixed-point coefficient. Each sample is multiplied by its coefficient, shifted back to sample scale and clamped to the signed full-scale range. A left sample and a right sample arrive together under one valid strobe. The scaled pair leaves one clock later.

Gain writes come in through two channel-select strobes that share a code bus and an update flag. A write with the update flag low only parks the code in a holding register for that channel. A write with the update flag high commits both channels at once. The written channel takes the code on the bus and the other channel takes its parked code. The commit can be held back until the channel's signal changes sign, which avoids audible steps. An optional timeout forces the change through on a signal that never crosses zero.

Top module: `dvol_stereo`

## Requirements
- R1: After reset, out_valid and both outputs are 0, every holding register holds code 195, and both channels run at code 195, which is unity gain.
- R2: A code X from 1 to 255 selects coefficient C = round(2^11 · 10^((X−195)/40)), capped at 65535. The output is floor(sample · C / 2^11).
- R3: An output that would exceed the signed range is clamped to +2^(W−1)−1 or −2^(W−1) and never wraps.
- R4: Code 0 gives coefficient 0, so the channel outputs exactly 0 for any input sample.
- R5: A write with wr_upd = 0 changes only the selected channel's holding register and leaves both active gains unchanged.
- R6: A write with wr_upd = 1 commits both channels. A selected channel takes wr_code and an unselected channel takes its holding register. The selected channel's holding register also takes wr_code.
- R7: With zc_en = 0, a committed gain applies to every sample presented from the second clock after the write clock onward.
- R8: With zc_en = 1, a committed gain stays pending. A channel crosses zero when the sign bit of a valid sample differs from the sign bit of that channel's previous valid sample, which counts as positive after reset. The crossing sample still uses the old gain, and the samples after it use the new gain.
- R9: With zc_en = 1 and to_en = 1, a pending change applies after 2^TO_LOG2 valid samples without a crossing. Those samples all use the old gain. With to_en = 0 the change stays pending for as long as no crossing occurs.
- R10: out_valid is in_valid delayed by one clock. While out_valid stays low, the outputs hold their last value.
- R11: If zc_en falls while a change is pending, the change applies on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Sample pair valid strobe |
| in_l | input | SAMPLE_W | Left sample, signed |
| in_r | input | SAMPLE_W | Right sample, signed |
| wr_l | input | 1 | Write strobe selecting the left channel |
| wr_r | input | 1 | Write strobe selecting the right channel |
| wr_code | input | CODE_W | Gain code carried by the write |
| wr_upd | input | 1 | Commit flag: 1 commits both channels |
| zc_en | input | 1 | Hold committed gains until a zero crossing |
| to_en | input | 1 | Allow the crossing timeout |
| out_valid | output | 1 | Scaled pair valid |
| out_l | output | SAMPLE_W | Scaled left sample, signed |
| out_r | output | SAMPLE_W | Scaled right sample, signed |

## Verification
The bench builds the block with 16-bit samples, 8-bit codes and a 16-bit coefficient. These are the default widths, so the coefficient values and the clamp limits it checks are the ones the block ships with. It shortens the timeout with TO_LOG2 = 5. With that setting the forced apply on the 32nd sample without a crossing can be reached in a few dozen samples. The bench also checks that no apply happens when the timeout is disabled.

// File: rtl/vol_pkg.sv
package vol_pkg;

   // Code that maps to 0 dB
   localparam int UNITY_CODE = 195;

   // Fixed-point coefficient for one gain code: round(2^frac * 10^((code-unity)/40)),
   // capped at the coefficient range; code 0 is a hard mute.
   function automatic int unsigned coef_of(input int code, input int unity,
                                           input int frac_w, input int mant_w);
      real g;
      real v;
      int unsigned lim;
      lim = (32'd1 << mant_w) - 32'd1;
      if (code == 0) return 0;
      g = 10.0 ** ((real'(code) - real'(unity)) / 40.0);
      v = g * real'(32'd1 << frac_w) + 0.5;
      if (v >= real'(lim)) return lim;
      return int'($rtoi(v));
   endfunction

endpackage

// File: rtl/vol_chan_ctrl.sv
module vol_chan_ctrl #(
   parameter int CODE_W     = 8,
   parameter int TO_LOG2    = 17,
   parameter int RESET_CODE = 195
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_sel,
   input  logic [CODE_W-1:0] wr_code,
   input  logic              commit,
   input  logic              in_valid,
   input  logic              sample_sign,
   input  logic              zc_en,
   input  logic              to_en,
   output logic [CODE_W-1:0] act_code,
   output logic              pending
);
   localparam logic [TO_LOG2-1:0] TO_LAST = '1;

   logic [CODE_W-1:0]  hold_code;
   logic [CODE_W-1:0]  target_code;
   logic [CODE_W-1:0]  commit_val;
   logic [TO_LOG2-1:0] quiet_cnt;
   logic               prev_sign;
   logic               crossed;
   logic               timed_out;
   logic               apply;

   assign commit_val = wr_sel ? wr_code : hold_code;
   assign crossed    = in_valid && (sample_sign != prev_sign);
   assign timed_out  = to_en && in_valid && (quiet_cnt == TO_LAST);
   assign apply      = pending && (!zc_en || crossed || timed_out);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_code   <= CODE_W'(RESET_CODE);
         target_code <= CODE_W'(RESET_CODE);
         act_code    <= CODE_W'(RESET_CODE);
         pending     <= 1'b0;
         prev_sign   <= 1'b0;
         quiet_cnt   <= '0;
      end else begin
         if (wr_sel) hold_code <= wr_code;
         if (in_valid) prev_sign <= sample_sign;

         if (commit || !pending) quiet_cnt <= '0;
         else if (in_valid)      quiet_cnt <= quiet_cnt + 1'b1;

         if (commit) begin
            target_code <= commit_val;
            pending     <= 1'b1;
         end else if (apply) begin
            act_code <= target_code;
            pending  <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/vol_scaler.sv
module vol_scaler #(
   parameter int SAMPLE_W = 16,
   parameter int CODE_W   = 8,
   parameter int MANT_W   = 16,
   parameter int FRAC_W   = 11,
   parameter int UNITY    = 195
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       in_valid,
   input  logic signed [SAMPLE_W-1:0] sample,
   input  logic [CODE_W-1:0]          code,
   output logic signed [SAMPLE_W-1:0] scaled
);
   localparam int NCODES = 1 << CODE_W;
   localparam int PW     = SAMPLE_W + MANT_W + 1;
   localparam logic signed [PW-1:0] HI = {{(PW-SAMPLE_W+1){1'b0}}, {(SAMPLE_W-1){1'b1}}};
   localparam logic signed [PW-1:0] LO = {{(PW-SAMPLE_W+1){1'b1}}, {(SAMPLE_W-1){1'b0}}};

   logic [MANT_W-1:0] coef_tab [NCODES];

   for (genvar i = 0; i < NCODES; i++) begin : g_lut
      localparam logic [MANT_W-1:0] COEF =
         MANT_W'(vol_pkg::coef_of(i, UNITY, FRAC_W, MANT_W));
      assign coef_tab[i] = COEF;
   end

   logic signed [PW-1:0] s_ext, c_ext, prod, shifted;
   logic signed [SAMPLE_W-1:0] clamped;

   always_comb begin
      s_ext   = {{(MANT_W+1){sample[SAMPLE_W-1]}}, sample};
      c_ext   = {{(SAMPLE_W+1){1'b0}}, coef_tab[code]};
      prod    = s_ext * c_ext;
      shifted = prod >>> FRAC_W;
      if (shifted > HI)      clamped = HI[SAMPLE_W-1:0];
      else if (shifted < LO) clamped = LO[SAMPLE_W-1:0];
      else                   clamped = shifted[SAMPLE_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        scaled <= '0;
      else if (in_valid) scaled <= clamped;
   end
endmodule

// File: rtl/dvol_stereo.sv
module dvol_stereo #(
   parameter int SAMPLE_W = 16,
   parameter int CODE_W   = 8,
   parameter int MANT_W   = 16,
   parameter int TO_LOG2  = 17
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       in_valid,
   input  logic signed [SAMPLE_W-1:0] in_l,
   input  logic signed [SAMPLE_W-1:0] in_r,
   input  logic                       wr_l,
   input  logic                       wr_r,
   input  logic [CODE_W-1:0]          wr_code,
   input  logic                       wr_upd,
   input  logic                       zc_en,
   input  logic                       to_en,
   output logic                       out_valid,
   output logic signed [SAMPLE_W-1:0] out_l,
   output logic signed [SAMPLE_W-1:0] out_r
);
   localparam int NCH    = 2;
   localparam int INT_W  = 5;               // integer bits: covers +30 dB (x31.6)
   localparam int FRAC_W = MANT_W - INT_W;

   if (SAMPLE_W < 4 || SAMPLE_W > 32) begin : g_bad_sample
      $error("dvol_stereo: SAMPLE_W out of range 4..32");
   end
   if (CODE_W < 8 || CODE_W > 10) begin : g_bad_code
      $error("dvol_stereo: CODE_W out of range 8..10");
   end
   if (MANT_W < 8 || MANT_W > 24) begin : g_bad_mant
      $error("dvol_stereo: MANT_W out of range 8..24");
   end
   if (TO_LOG2 < 2 || TO_LOG2 > 24) begin : g_bad_to
      $error("dvol_stereo: TO_LOG2 out of range 2..24");
   end

   logic                       commit;
   logic [NCH-1:0]             wr_sel;
   logic signed [SAMPLE_W-1:0] s_in  [NCH];
   logic signed [SAMPLE_W-1:0] s_out [NCH];
   logic [CODE_W-1:0]          act_code [NCH];
   logic [NCH-1:0]             pend;

   assign commit = wr_upd && (wr_l || wr_r);
   assign wr_sel = {wr_r, wr_l};
   assign s_in[0] = in_l;
   assign s_in[1] = in_r;

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      vol_chan_ctrl #(
         .CODE_W     (CODE_W),
         .TO_LOG2    (TO_LOG2),
         .RESET_CODE (vol_pkg::UNITY_CODE)
      ) u_ctrl (
         .clk         (clk),
         .rst_n       (rst_n),
         .wr_sel      (wr_sel[c]),
         .wr_code     (wr_code),
         .commit      (commit),
         .in_valid    (in_valid),
         .sample_sign (s_in[c][SAMPLE_W-1]),
         .zc_en       (zc_en),
         .to_en       (to_en),
         .act_code    (act_code[c]),
         .pending     (pend[c])
      );

      vol_scaler #(
         .SAMPLE_W (SAMPLE_W),
         .CODE_W   (CODE_W),
         .MANT_W   (MANT_W),
         .FRAC_W   (FRAC_W),
         .UNITY    (vol_pkg::UNITY_CODE)
      ) u_scale (
         .clk      (clk),
         .rst_n    (rst_n),
         .in_valid (in_valid),
         .sample   (s_in[c]),
         .code     (act_code[c]),
         .scaled   (s_out[c])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) out_valid <= 1'b0;
      else        out_valid <= in_valid;
   end

   assign out_l = s_out[0];
   assign out_r = s_out[1];
endmodule

// File: rtl/dvol_stereo_chk.sv
module dvol_stereo_chk #(
   parameter int SAMPLE_W = 16,
   parameter int CODE_W   = 8
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       in_valid,
   input logic signed [SAMPLE_W-1:0] in_l,
   input logic                       wr_l,
   input logic                       wr_r,
   input logic                       wr_upd,
   input logic                       zc_en,
   input logic                       out_valid,
   input logic signed [SAMPLE_W-1:0] out_l,
   input logic [CODE_W-1:0]          act_l,
   input logic                       pend_l
);
   localparam logic signed [SAMPLE_W-1:0] S_MAX = {1'b0, {(SAMPLE_W-1){1'b1}}};
   localparam logic [CODE_W-1:0]          C_TOP = '1;

   logic commit;
   assign commit = wr_upd && (wr_l || wr_r);

   p_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   p_novalid_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!out_valid && $stable(out_l)));
   p_mute_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && act_l == '0) |=> (out_l == '0));
   p_clamp_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && act_l == C_TOP && in_l == S_MAX) |=> (out_l == S_MAX));
   p_staged_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ((wr_l || wr_r) && !wr_upd && !pend_l) |=> $stable(act_l));
   p_nozc_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_l && !zc_en && !commit) |=> !pend_l);
   p_zc_wait_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_l && zc_en && !in_valid && !commit) |=> (pend_l && $stable(act_l)));
endmodule

bind dvol_stereo dvol_stereo_chk #(
   .SAMPLE_W (SAMPLE_W),
   .CODE_W   (CODE_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_l      (in_l),
   .wr_l      (wr_l),
   .wr_r      (wr_r),
   .wr_upd    (wr_upd),
   .zc_en     (zc_en),
   .out_valid (out_valid),
   .out_l     (out_l),
   .act_l     (act_code[0]),
   .pend_l    (pend[0])
);

// File: tb/dvol_stereo_test.sv
module dvol_stereo_test;
   localparam int SW   = 16;
   localparam int CW   = 8;
   localparam int TOL2 = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0;
   logic signed [SW-1:0] in_l = '0, in_r = '0;
   logic wr_l = 1'b0, wr_r = 1'b0, wr_upd = 1'b0;
   logic [CW-1:0] wr_code = '0;
   logic zc_en = 1'b0, to_en = 1'b0;
   logic out_valid;
   logic signed [SW-1:0] out_l, out_r;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   dvol_stereo #(.SAMPLE_W(SW), .CODE_W(CW), .MANT_W(16), .TO_LOG2(TOL2)) uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_l(in_l), .in_r(in_r),
      .wr_l(wr_l), .wr_r(wr_r), .wr_code(wr_code), .wr_upd(wr_upd),
      .zc_en(zc_en), .to_en(to_en), .out_valid(out_valid), .out_l(out_l), .out_r(out_r));

   function automatic longint expect_out(input longint s, input int code);
      longint c, p, q;
      real g;
      if (code == 0) c = 0;
      else begin
         g = 10.0 ** ((real'(code) - 195.0) / 40.0);
         c = longint'($rtoi(g * 2048.0 + 0.5));
         if (c > 65535) c = 65535;
      end
      p = s * c;
      q = p >>> 11;
      if (q > 32767) q = 32767;
      if (q < -32768) q = -32768;
      return q;
   endfunction

   task automatic check(input string req, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wr(input bit l, input bit r, input int code, input bit upd);
      @(negedge clk);
      wr_l = l; wr_r = r; wr_code = CW'(code); wr_upd = upd;
      @(negedge clk);
      wr_l = 1'b0; wr_r = 1'b0; wr_upd = 1'b0;
   endtask

   task automatic push(input longint l, input longint r);
      @(negedge clk);
      in_valid = 1'b1; in_l = SW'(l); in_r = SW'(r);
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic push_chk(input string req, input longint l, input longint r,
                           input int cl, input int cr);
      push(l, r);
      check(req, longint'(out_l), expect_out(l, cl));
      check(req, longint'(out_r), expect_out(r, cr));
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_fail++; n_chk++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 out_valid", longint'(out_valid), 0);
      check("R1 out_l", longint'(out_l), 0);
      check("R1 out_r", longint'(out_r), 0);
      rst_n = 1'b1;
      push_chk("R1 unity", 1000, -1000, 195, 195);
      check("R1 unity exact", longint'(out_l), 1000);
      check("R10 valid one clock later", longint'(out_valid), 1);
      @(negedge clk);
      check("R10 valid drops", longint'(out_valid), 0);
      check("R10 hold", longint'(out_l), 1000);

      // R5 staged write leaves gain alone; R6 commit pulls other channel's hold
      wr(1, 0, 235, 0);
      push_chk("R5 staged no effect", 1000, 1000, 195, 195);
      wr(0, 1, 155, 1);
      push_chk("R6 commit both", 1000, 1000, 235, 155);
      check("R2 +20dB", longint'(out_l), 10000);
      check("R2 -20dB", longint'(out_r), 100);

      // R3 clamp at top code
      wr(1, 1, 255, 1);
      push_chk("R3 clamp", 32767, -32768, 255, 255);
      check("R3 pos limit", longint'(out_l), 32767);
      check("R3 neg limit", longint'(out_r), -32768);
      push_chk("R3 in range", 20, -20, 255, 255);

      // R4 mute; right takes its holding (255)
      wr(1, 0, 0, 1);
      push_chk("R4 mute", -32768, 5, 0, 255);
      check("R4 zero", longint'(out_l), 0);

      // R6 explicit stage and cross-commit
      wr(0, 1, 100, 0);
      wr(1, 0, 195, 1);
      push_chk("R6 cross commit", 3000, 3000, 195, 100);

      // R8 zero-cross hold
      zc_en = 1'b1;
      push_chk("R8 setup", 100, 100, 195, 100);
      wr(0, 1, 210, 0);
      wr(1, 0, 175, 1);
      push_chk("R8 pending no cross", 200, 300, 195, 100);
      push_chk("R8 crossing sample old", -200, 300, 195, 100);
      push_chk("R8 left after cross", -200, 300, 175, 100);
      push_chk("R8 right crossing old", -50, -300, 175, 100);
      push_chk("R8 right after cross", -50, -300, 175, 210);

      // R11 zc_en drop applies pending change
      wr(1, 0, 195, 1);
      push_chk("R11 still pending", -50, -300, 175, 210);
      @(negedge clk);
      zc_en = 1'b0;
      push_chk("R11 applied on drop", -50, -300, 195, 210);

      // R9 timeout disabled: stays pending
      zc_en = 1'b1; to_en = 1'b0;
      wr(1, 0, 215, 1);
      for (int i = 0; i < 40; i++) push_chk("R9 no timeout", -(100 + i), -300, 195, 210);
      // R9 timeout enabled: 32 samples old, then new
      to_en = 1'b1;
      wr(1, 0, 225, 1);
      for (int i = 0; i < (1 << TOL2); i++)
         push_chk("R9 before timeout", -(200 + i), -300, 195, 210);
      push_chk("R9 after timeout", -77, -300, 225, 210);
      zc_en = 1'b0; to_en = 1'b0;

      // R2/R7 constrained random with zc off
      for (int k = 0; k < 60; k++) begin
         int cl, cr;
         cl = int'($urandom_range(255, 0));
         cr = int'($urandom_range(255, 0));
         wr(1, 0, cl, 0);
         wr(0, 1, cr, 1);
         for (int j = 0; j < 3; j++) begin
            longint sl, sr;
            sl = longint'($urandom_range(65535, 0)) - 32768;
            sr = (j == 0) ? longint'(-32768) : longint'($urandom_range(65535, 0)) - 32768;
            push_chk("R2 R7 random", sl, sr, cl, cr);
         end
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule